// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block paces a display link. It counts pixel clocks inside each line and inside the whole frame. It drives horizontal sync, vertical sync and data-enable, and any of the three can be inverted. All vertical limits are absolute pixel-clock positions counted from the start of the frame, so a horizontal skew is folded into those numbers when they are written. A display window marks where data-enable is asserted. An optional inner active window can be enabled on either axis. Pixels that lie inside the display window but outside an enabled active window carry a fixed border colour.

A word-addressed write bus programs the block. Word 0 is the run control: bit 0 runs the engine, bit 1 lets the frame count advance and bit 2 lets the line count advance. Word 1 holds the mode bits: bit 29 enables the active window horizontally, bit 30 enables it vertically and bit 31 enables the fetch trigger. Words 2 to 10 hold the geometry:
- word 2: line total in bits 31:16 and hsync width in bits 15:0
- word 3: frame period in pixel clocks
- word 4: vsync width in pixel clocks
- word 5: display horizontal window, end in bits 31:16 and start in bits 15:0
- words 6 and 7: display vertical start and end
- word 8: active horizontal window, end in bits 31:16 and start in bits 15:0
- words 9 and 10: active vertical start and end

Word 11 is the border colour, word 12 the underflow colour, word 13 the polarity and word 14 the fetch-start position. The block also reports a frame count and a line count for status.

Top module: `raster_timing_gen`

## Requirements
- R1: Once synchronous reset has been released, every register is zero. With no further writes, hsync, vsync, de, pix_out, fetch_pulse, frame_cnt and line_cnt all read 0.
- R2: While running, the in-line pixel position counts 0 up to line total − 1 (word 2 bits 31:16) and then returns to 0. Hsync is active while that position is below word 2 bits 15:0.
- R3: While running, the in-frame position counts 0 up to word 3 − 1 and then returns to 0. At that point the in-line position also returns to 0. Vsync is active while the in-frame position is below word 4.
- R4: de is active when the in-line position lies in the inclusive range given by word 5 (start in bits 15:0, end in bits 31:16) and the in-frame position lies in the inclusive range from word 6 to word 7.
- R5: While de is active, pix_out is the border colour (word 11, bits 23:0) if word 1 bit 29 is set and the in-line position is outside word 8's inclusive range. The same applies if word 1 bit 30 is set and the in-frame position is outside the inclusive range from word 9 to word 10.
- R6: Inside the display window and the active window, pix_out is pix_in when pix_in_valid is 1 and the underflow colour (word 12, bits 23:0) when it is 0. Outside the display window, pix_out is 0.
- R7: Word 13 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R8: While word 0 bit 0 is clear, both positions and both counts return to 0 on the next clock. hsync, vsync and de then sit at the inactive level set by word 13, and pix_out and fetch_pulse are 0.
- R9: At each frame wrap, frame_cnt increments if word 0 bit 1 is set. line_cnt increments at each line end other than a frame wrap if word 0 bit 2 is set, and it clears at every frame wrap.
- R10: fetch_pulse is 1 exactly while running, with word 1 bit 31 set and the in-frame position equal to word 14.
- R11: Writes to words 2 to 10 reach the working geometry only while the engine is stopped or on the clock where a frame wraps. A write that lands on that same wrap clock waits for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| pix_in | input | 24 | Upstream pixel |
| pix_in_valid | input | 1 | Upstream pixel is valid |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pix_out | output | 24 | Output pixel |
| fetch_pulse | output | 1 | Programmable fetch trigger |
| frame_cnt | output | STAT_W | Frames completed |
| line_cnt | output | STAT_W | Lines completed in the current frame |

## Verification
Two things can fall on the same clock: the wrap that loads the working geometry, and a geometry write arriving on the bus. The bench provokes this by watching its own frame position and timing a line-total write so that it is captured exactly on the last pixel of a frame. Its reference model keeps the old geometry for the frame that begins on that clock. Any early adoption therefore shows up as a sync or de mismatch on the very next line. Border fill and underflow also overlap inside the display window. A random pixel-valid pattern exercises both, and a border pixel must not turn into the underflow colour.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
    localparam int REG_W    = 32;
    localparam int HALF_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int PIX_W    = 24;
    localparam int NUM_REGS = 15;

    localparam logic [ADDR_W-1:0] A_RUN     = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE    = 4'd1;
    localparam logic [ADDR_W-1:0] A_HTIME   = 4'd2;
    localparam logic [ADDR_W-1:0] A_VPER    = 4'd3;
    localparam logic [ADDR_W-1:0] A_VPULSE  = 4'd4;
    localparam logic [ADDR_W-1:0] A_DISP_H  = 4'd5;
    localparam logic [ADDR_W-1:0] A_DISP_VS = 4'd6;
    localparam logic [ADDR_W-1:0] A_DISP_VE = 4'd7;
    localparam logic [ADDR_W-1:0] A_ACT_H   = 4'd8;
    localparam logic [ADDR_W-1:0] A_ACT_VS  = 4'd9;
    localparam logic [ADDR_W-1:0] A_ACT_VE  = 4'd10;
    localparam logic [ADDR_W-1:0] A_BORDER  = 4'd11;
    localparam logic [ADDR_W-1:0] A_UFLOW   = 4'd12;
    localparam logic [ADDR_W-1:0] A_POL     = 4'd13;
    localparam logic [ADDR_W-1:0] A_FETCH   = 4'd14;

    localparam int MODE_ACT_H = 29;
    localparam int MODE_ACT_V = 30;
    localparam int MODE_FETCH = 31;

    typedef struct packed {
        logic [HALF_W-1:0] htotal;
        logic [HALF_W-1:0] hpulse;
        logic [HALF_W-1:0] dh_lo;
        logic [HALF_W-1:0] dh_hi;
        logic [HALF_W-1:0] ah_lo;
        logic [HALF_W-1:0] ah_hi;
        logic [REG_W-1:0]  vper;
        logic [REG_W-1:0]  vpulse;
        logic [REG_W-1:0]  dv_lo;
        logic [REG_W-1:0]  dv_hi;
        logic [REG_W-1:0]  av_lo;
        logic [REG_W-1:0]  av_hi;
    } geom_t;

    typedef struct packed {
        logic       run;
        logic       frame_en;
        logic       line_en;
        logic       act_h_en;
        logic       act_v_en;
        logic       fetch_en;
        logic [2:0] pol;
    } ctrl_t;

    function automatic logic within_h(logic [HALF_W-1:0] v, logic [HALF_W-1:0] lo,
                                      logic [HALF_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic within_f(logic [REG_W-1:0] v, logic [REG_W-1:0] lo,
                                      logic [REG_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction
endpackage

// File: rtl/rtg_regs.sv
`timescale 1ns/1ps
module rtg_regs
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              frame_wrap,
    output ctrl_t             ctrl,
    output geom_t             geom_w,
    output logic [PIX_W-1:0]  border_clr,
    output logic [PIX_W-1:0]  uflow_clr,
    output logic [REG_W-1:0]  fetch_at
);
    logic [REG_W-1:0] live_q [NUM_REGS];
    geom_t            geom_live;
    geom_t            geom_q;
    logic             load;
    logic             unused_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) live_q[i] <= '0;
        end else if (we && (int'(addr) < NUM_REGS)) begin
            live_q[addr] <= wdata;
        end
    end

    always_comb begin
        geom_live.htotal = live_q[A_HTIME][REG_W-1:HALF_W];
        geom_live.hpulse = live_q[A_HTIME][HALF_W-1:0];
        geom_live.vper   = live_q[A_VPER];
        geom_live.vpulse = live_q[A_VPULSE];
        geom_live.dh_lo  = live_q[A_DISP_H][HALF_W-1:0];
        geom_live.dh_hi  = live_q[A_DISP_H][REG_W-1:HALF_W];
        geom_live.dv_lo  = live_q[A_DISP_VS];
        geom_live.dv_hi  = live_q[A_DISP_VE];
        geom_live.ah_lo  = live_q[A_ACT_H][HALF_W-1:0];
        geom_live.ah_hi  = live_q[A_ACT_H][REG_W-1:HALF_W];
        geom_live.av_lo  = live_q[A_ACT_VS];
        geom_live.av_hi  = live_q[A_ACT_VE];
    end

    assign load = !live_q[A_RUN][0] || frame_wrap;

    always_ff @(posedge clk) begin
        if (rst)       geom_q <= '0;
        else if (load) geom_q <= geom_live;
    end

    assign geom_w        = geom_q;
    assign ctrl.run      = live_q[A_RUN][0];
    assign ctrl.frame_en = live_q[A_RUN][1];
    assign ctrl.line_en  = live_q[A_RUN][2];
    assign ctrl.act_h_en = live_q[A_MODE][MODE_ACT_H];
    assign ctrl.act_v_en = live_q[A_MODE][MODE_ACT_V];
    assign ctrl.fetch_en = live_q[A_MODE][MODE_FETCH];
    assign ctrl.pol      = live_q[A_POL][2:0];
    assign border_clr    = live_q[A_BORDER][PIX_W-1:0];
    assign uflow_clr     = live_q[A_UFLOW][PIX_W-1:0];
    assign fetch_at      = live_q[A_FETCH];

    assign unused_bits = ^{live_q[A_RUN][REG_W-1:3], live_q[A_MODE][MODE_ACT_H-1:0],
                           live_q[A_BORDER][REG_W-1:PIX_W], live_q[A_UFLOW][REG_W-1:PIX_W],
                           live_q[A_POL][REG_W-1:3]};
endmodule

// File: rtl/rtg_counters.sv
`timescale 1ns/1ps
module rtg_counters
    import rtg_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [HALF_W-1:0] htotal,
    input  logic [REG_W-1:0]  vper,
    output logic [HALF_W-1:0] hpos,
    output logic [REG_W-1:0]  fpos,
    output logic [STAT_W-1:0] frame_cnt,
    output logic [STAT_W-1:0] line_cnt,
    output logic              frame_wrap
);
    logic line_end;
    logic frame_end;

    assign line_end   = ({1'b0, hpos} + 1'b1) >= {1'b0, htotal};
    assign frame_end  = ({1'b0, fpos} + 1'b1) >= {1'b0, vper};
    assign frame_wrap = ctrl.run && frame_end;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) begin
            hpos      <= '0;
            fpos      <= '0;
            frame_cnt <= '0;
            line_cnt  <= '0;
        end else if (frame_end) begin
            hpos     <= '0;
            fpos     <= '0;
            line_cnt <= '0;
            if (ctrl.frame_en) frame_cnt <= frame_cnt + 1'b1;
        end else begin
            fpos <= fpos + 1'b1;
            if (line_end) begin
                hpos <= '0;
                if (ctrl.line_en) line_cnt <= line_cnt + 1'b1;
            end else begin
                hpos <= hpos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtg_raster.sv
`timescale 1ns/1ps
module rtg_raster
    import rtg_pkg::*;
(
    input  ctrl_t             ctrl,
    input  geom_t             geom,
    input  logic [HALF_W-1:0] hpos,
    input  logic [REG_W-1:0]  fpos,
    input  logic [PIX_W-1:0]  border_clr,
    input  logic [PIX_W-1:0]  uflow_clr,
    input  logic [REG_W-1:0]  fetch_at,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              pix_in_valid,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  pix_out,
    output logic              fetch_pulse
);
    logic hs_on, vs_on, in_disp, in_act;

    always_comb begin
        hs_on   = ctrl.run && (hpos < geom.hpulse);
        vs_on   = ctrl.run && (fpos < geom.vpulse);
        in_disp = ctrl.run && within_h(hpos, geom.dh_lo, geom.dh_hi)
                           && within_f(fpos, geom.dv_lo, geom.dv_hi);
        in_act  = (!ctrl.act_h_en || within_h(hpos, geom.ah_lo, geom.ah_hi))
               && (!ctrl.act_v_en || within_f(fpos, geom.av_lo, geom.av_hi));

        if (!in_disp)          pix_out = '0;
        else if (!in_act)      pix_out = border_clr;
        else if (!pix_in_valid) pix_out = uflow_clr;
        else                   pix_out = pix_in;
    end

    assign hsync       = hs_on   ^ ctrl.pol[0];
    assign vsync       = vs_on   ^ ctrl.pol[1];
    assign de          = in_disp ^ ctrl.pol[2];
    assign fetch_pulse = ctrl.run && ctrl.fetch_en && (fpos == fetch_at);
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [23:0]       pix_in,
    input  logic              pix_in_valid,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [23:0]       pix_out,
    output logic              fetch_pulse,
    output logic [STAT_W-1:0] frame_cnt,
    output logic [STAT_W-1:0] line_cnt
);
    ctrl_t             ctrl;
    geom_t             geom_w;
    logic [PIX_W-1:0]  border_clr;
    logic [PIX_W-1:0]  uflow_clr;
    logic [REG_W-1:0]  fetch_at;
    logic [HALF_W-1:0] hpos;
    logic [REG_W-1:0]  fpos;
    logic              frame_wrap;

    rtg_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .frame_wrap(frame_wrap), .ctrl(ctrl), .geom_w(geom_w),
        .border_clr(border_clr), .uflow_clr(uflow_clr), .fetch_at(fetch_at)
    );

    rtg_counters #(.STAT_W(STAT_W)) u_cnt (
        .clk(clk), .rst(rst), .ctrl(ctrl), .htotal(geom_w.htotal), .vper(geom_w.vper),
        .hpos(hpos), .fpos(fpos), .frame_cnt(frame_cnt), .line_cnt(line_cnt),
        .frame_wrap(frame_wrap)
    );

    rtg_raster u_raster (
        .ctrl(ctrl), .geom(geom_w), .hpos(hpos), .fpos(fpos),
        .border_clr(border_clr), .uflow_clr(uflow_clr), .fetch_at(fetch_at),
        .pix_in(pix_in), .pix_in_valid(pix_in_valid),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
        .fetch_pulse(fetch_pulse)
    );
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
module rtg_checker #(
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              fetch_en,
    input logic [2:0]        pol,
    input logic [15:0]       hpos,
    input logic [15:0]       htotal,
    input logic [31:0]       fpos,
    input logic [STAT_W-1:0] frame_cnt,
    input logic [STAT_W-1:0] line_cnt,
    input logic              hsync,
    input logic              vsync,
    input logic              de,
    input logic              fetch_pulse
);
    p_idle_sync_r8: assert property (@(posedge clk) disable iff (rst)
        !run |-> (hsync == pol[0] && vsync == pol[1] && de == pol[2] && !fetch_pulse));

    p_idle_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> (frame_cnt == '0 && line_cnt == '0 && hpos == '0 && fpos == '0));

    p_fetch_gate_r10: assert property (@(posedge clk) disable iff (rst)
        fetch_pulse |-> (run && fetch_en));

    p_hpos_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (run && htotal != '0) |-> (hpos < htotal));

    p_line_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (run && fpos == '0) |-> (line_cnt == '0));

    p_fpos_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && fpos != '0) |-> (fpos == $past(fpos) + 32'd1));
endmodule

bind raster_timing_gen rtg_checker #(.STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst(rst), .run(ctrl.run), .fetch_en(ctrl.fetch_en), .pol(ctrl.pol),
    .hpos(hpos), .htotal(geom_w.htotal), .fpos(fpos),
    .frame_cnt(frame_cnt), .line_cnt(line_cnt),
    .hsync(hsync), .vsync(vsync), .de(de), .fetch_pulse(fetch_pulse)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;
    localparam int STAT_W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [23:0]       pix_in = '0;
    logic              pix_in_valid = 1'b0;
    logic              hsync, vsync, de, fetch_pulse;
    logic [23:0]       pix_out;
    logic [STAT_W-1:0] frame_cnt, line_cnt;

    raster_timing_gen #(.STAT_W(STAT_W)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .pix_in(pix_in), .pix_in_valid(pix_in_valid), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_out(pix_out), .fetch_pulse(fetch_pulse),
        .frame_cnt(frame_cnt), .line_cnt(line_cnt)
    );

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference: live registers, working geometry, positions
    logic [31:0]       mr [0:14];
    logic [31:0]       mw [0:14];
    longint            hc, fc;
    logic [STAT_W-1:0] mf, ml;

    always @(posedge clk) begin : model
        bit run_now, l_end, f_end;
        if (rst) begin
            for (int k = 0; k < 15; k++) begin mr[k] = '0; mw[k] = '0; end
            hc = 0; fc = 0; mf = '0; ml = '0;
        end else begin
            run_now = mr[0][0];
            if (!run_now) begin
                hc = 0; fc = 0; mf = '0; ml = '0;
                for (int k = 2; k <= 10; k++) mw[k] = mr[k];
            end else begin
                l_end = (hc + 1) >= longint'(mw[2][31:16]);
                f_end = (fc + 1) >= longint'(mw[3]);
                if (f_end) begin
                    hc = 0; fc = 0; ml = '0;
                    if (mr[0][1]) mf = mf + 1'b1;
                    for (int k = 2; k <= 10; k++) mw[k] = mr[k];
                end else begin
                    fc = fc + 1;
                    if (l_end) begin
                        hc = 0;
                        if (mr[0][2]) ml = ml + 1'b1;
                    end else begin
                        hc = hc + 1;
                    end
                end
            end
            if (reg_we && reg_addr < 4'd15) mr[reg_addr] = reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin : compare
        bit run_m, hs_a, vs_a, disp, act, f_e;
        logic [2:0]  pol;
        logic [23:0] px;
        if (cmp_on && !done) begin
            run_m = mr[0][0];
            pol   = mr[13][2:0];
            hs_a  = run_m && (hc < longint'(mw[2][15:0]));
            vs_a  = run_m && (fc < longint'(mw[4]));
            disp  = run_m && hc >= longint'(mw[5][15:0]) && hc <= longint'(mw[5][31:16])
                          && fc >= longint'(mw[6]) && fc <= longint'(mw[7]);
            act   = (!mr[1][29] || (hc >= longint'(mw[8][15:0]) && hc <= longint'(mw[8][31:16])))
                 && (!mr[1][30] || (fc >= longint'(mw[9]) && fc <= longint'(mw[10])));
            if (!disp)              px = '0;
            else if (!act)          px = mr[11][23:0];
            else if (!pix_in_valid) px = mr[12][23:0];
            else                    px = pix_in;
            f_e = run_m && mr[1][31] && (fc == longint'(mw[0]) * 0 + longint'(mr[14]));
            chk(hsync == (hs_a ^ pol[0]), "R2 R7 R11 hsync", hsync, hs_a ^ pol[0]);
            chk(vsync == (vs_a ^ pol[1]), "R3 R7 R11 vsync", vsync, vs_a ^ pol[1]);
            chk(de == (disp ^ pol[2]), "R4 R7 R8 de", de, disp ^ pol[2]);
            chk(pix_out == px, "R5 R6 pix_out", pix_out, px);
            chk(fetch_pulse == f_e, "R10 fetch_pulse", fetch_pulse, f_e);
            chk(frame_cnt == mf, "R9 frame_cnt", frame_cnt, mf);
            chk(line_cnt == ml, "R9 line_cnt", line_cnt, ml);
        end
    end

    // upstream pixel stream with a pseudo-random valid pattern
    initial begin : pixsrc
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pix_in       = {lfsr[7:0], lfsr[15:8], lfsr[11:4]};
            pix_in_valid = lfsr[0] | lfsr[3];
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin : watchdog
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin : stim
        idle(3);
        #1 rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk({hsync, vsync, de, fetch_pulse} == 4'b0, "R1 syncs after reset", {hsync, vsync, de, fetch_pulse}, 0);
        chk(pix_out == '0 && frame_cnt == '0 && line_cnt == '0, "R1 data after reset",
            {pix_out, frame_cnt, line_cnt}, 0);

        // geometry: line total 10, frame 6 lines
        wr(4'd2, {16'd10, 16'd2});
        wr(4'd3, 32'd60);
        wr(4'd4, 32'd10);
        wr(4'd5, {16'd8, 16'd4});
        wr(4'd6, 32'd20);
        wr(4'd7, 32'd49);
        wr(4'd8, {16'd7, 16'd5});
        wr(4'd9, 32'd30);
        wr(4'd10, 32'd39);
        wr(4'd11, 32'h00B0B0B0);
        wr(4'd12, 32'h000F0F0F);
        wr(4'd14, 32'd55);
        wr(4'd0, 32'd7);
        idle(185);

        // border fill and fetch trigger
        wr(4'd1, 32'hE000_0000);
        idle(130);
        wr(4'd1, 32'h2000_0000);
        idle(70);
        wr(4'd1, 32'hC000_0000);
        idle(70);

        // inverted polarity
        wr(4'd13, 32'd7);
        idle(65);
        wr(4'd13, 32'd2);
        idle(20);

        // R11: geometry write captured on the wrap clock, then mid-frame writes
        begin
            forever begin
                @(posedge clk); #1;
                if (fc == 59) break;
            end
            reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = {16'd12, 16'd3};
            @(posedge clk); #1;
            reg_we = 1'b0;
        end
        idle(7);
        wr(4'd3, 32'd72);
        wr(4'd4, 32'd12);
        wr(4'd5, {16'd10, 16'd4});
        wr(4'd6, 32'd24);
        wr(4'd7, 32'd59);
        wr(4'd8, {16'd8, 16'd6});
        wr(4'd9, 32'd36);
        wr(4'd10, 32'd47);
        wr(4'd14, 32'd70);
        idle(230);

        // counts held while their enables are off
        wr(4'd0, 32'd1);
        idle(160);
        wr(4'd0, 32'd5);
        idle(100);

        // R8: engine stop with all outputs inverted
        wr(4'd13, 32'd7);
        wr(4'd0, 32'd0);
        idle(2);
        @(negedge clk);
        chk(hsync && vsync && de, "R8 idle levels", {hsync, vsync, de}, 3'b111);
        chk(frame_cnt == '0 && line_cnt == '0 && pix_out == '0 && !fetch_pulse,
            "R8 idle counts", {frame_cnt, line_cnt}, 0);
        idle(20);

        // restart from zero
        wr(4'd13, 32'd0);
        wr(4'd0, 32'd7);
        idle(160);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule